// File: doc/BRIEF.md
# Tagged Programmable Functional Unit

This block is an extra functional unit that sits next to a processor's register file and executes user-defined instructions. Each issued instruction carries an 11-bit user-instruction identifier and two 32-bit register operands. The unit compares that identifier with the identifier of the configuration it currently holds. On a match it returns a 32-bit result in the same cycle, through a purely combinational path. On a mismatch it raises a miss fault instead. Trap software then installs the right configuration and the instruction is issued again.

The configuration is an identifier plus a 3-bit selector that picks one of eight built-in datapath variants. It is written through a one-cycle load port. The unit keeps no data between instructions, so a processor context switch needs no save or restore of it.

The issue side is a valid/ready interface. `iss_ready` is low only in a cycle where the load port is writing. In such a cycle an issue is not accepted: it produces neither a result nor a fault, and the processor holds the issue until `iss_ready` is high again. The result side has no back-pressure, because the register file write port always accepts. `res_valid` and `fault` are plain status pins that relate to the issue accepted in the same cycle.

Top module: `tpfu_unit`

## Requirements
- R1: After reset the held configuration is invalid. The first accepted issue, whatever its identifier, raises `fault` and leaves `res_valid` low.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) whose identifier equals the held valid identifier raises `res_valid` in the same cycle, with `res_data` equal to the selected function of the operands.
- R3: An accepted issue whose identifier differs from the held one raises `fault` in that cycle only, keeps `res_valid` low and drives `res_data` to zero.
- R4: `fault` and `res_valid` are never high together, and neither is high in a cycle without an accepted issue. `res_data` is zero whenever `res_valid` is low.
- R5: When `cfg_we` is high, `cfg_id` and `cfg_sel` are captured at that clock edge and take effect from the next cycle. `iss_ready` is low in the `cfg_we` cycle and high in every other cycle.
- R6: Function selector encodings:
  - 0: a+b modulo 2^32
  - 1: a-b modulo 2^32
  - 2: a xor b
  - 3: a and b
  - 4: a shifted left by b[4:0]
  - 5: a shifted right logically by b[4:0]
  - 6: the population count of a, zero-extended
  - 7: a with its four bytes reversed (byte 0 moves to bits 31:24)
- R7: The unit is stateless with respect to data. Identical operands, identifier and configuration give the identical result, whatever instructions came before.
- R8: All 11 identifier bits take part in the compare. An identifier that differs from the held one in bit 10 alone misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue strobe for a user instruction |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_id | input | 11 | User-instruction identifier |
| iss_a | input | 32 | First register operand |
| iss_b | input | 32 | Second register operand |
| res_valid | output | 1 | Hit: result valid this cycle |
| res_data | output | 32 | Result, zero when not valid |
| fault | output | 1 | Miss fault for the accepted issue |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_id | input | 11 | Identifier to install |
| cfg_sel | input | 3 | Function selector to install |

## Verification
The only state in this block is the held identifier, its valid flag and the selector. If any of them is wrong, it shows up on the very next accepted issue. A wrong identifier or valid flag turns a hit into a miss fault, or a miss into a result. A wrong selector gives a `res_data` that differs from the bench's model of the chosen function. The bench therefore loads a configuration and issues in the following cycle, for every selector. It also probes neighbouring identifiers, the bit-10 difference and the load cycle itself, so that every corruption is caught within one cycle of the load.

// File: rtl/tpfu_pkg.sv
package tpfu_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_XOR  = 3'd2,
    FN_AND  = 3'd3,
    FN_SHL  = 3'd4,
    FN_SHR  = 3'd5,
    FN_POP  = 3'd6,
    FN_BREV = 3'd7
  } fn_e;
endpackage

// File: rtl/tpfu_cfg_reg.sv
module tpfu_cfg_reg
  import tpfu_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] wr_id,
  input  logic [SEL_W-1:0] wr_sel,
  output logic            held_valid,
  output logic [ID_W-1:0] held_id,
  output fn_e             held_fn
);
  // Identifier, valid flag and selector are loaded together; reset clears the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_id    <= '0;
      held_fn    <= FN_ADD;
    end else if (we) begin
      held_valid <= 1'b1;
      held_id    <= wr_id;
      held_fn    <= fn_e'(wr_sel);
    end
  end
endmodule

// File: rtl/tpfu_tag_cmp.sv
module tpfu_tag_cmp #(
  parameter int ID_W = 11
) (
  input  logic            held_valid,
  input  logic [ID_W-1:0] held_id,
  input  logic [ID_W-1:0] req_id,
  output logic            hit
);
  logic [ID_W-1:0] diff;

  // Bitwise difference reduced so that every identifier bit counts.
  always_comb begin
    diff = held_id ^ req_id;
    hit  = held_valid && (diff == '0);
  end
endmodule

// File: rtl/tpfu_func_core.sv
module tpfu_func_core
  import tpfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int NBYTES = DATA_W / 8;

  logic [CNT_W-1:0]  pop_cnt;
  logic [DATA_W-1:0] brev;
  logic [SH_W-1:0]   sh_amt;

  // Byte reversal is pure wiring, one slice per byte lane.
  for (genvar g = 0; g < NBYTES; g++) begin : g_brev
    assign brev[8*g +: 8] = a[8*(NBYTES-1-g) +: 8];
  end

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pop_cnt = pop_cnt + CNT_W'(a[i]);
    end
  end

  assign sh_amt = b[SH_W-1:0];

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_XOR:  y = a ^ b;
      FN_AND:  y = a & b;
      FN_SHL:  y = a << sh_amt;
      FN_SHR:  y = a >> sh_amt;
      FN_POP:  y = DATA_W'(pop_cnt);
      FN_BREV: y = brev;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tpfu_unit.sv
module tpfu_unit
  import tpfu_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [ID_W-1:0]   iss_id,
  input  logic [DATA_W-1:0] iss_a,
  input  logic [DATA_W-1:0] iss_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              fault,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [SEL_W-1:0]  cfg_sel
);
  logic            held_valid;
  logic [ID_W-1:0] held_id;
  fn_e             held_fn;
  logic            hit;
  logic            accept;
  logic [DATA_W-1:0] core_y;

  tpfu_cfg_reg #(.ID_W(ID_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wr_id     (cfg_id),
    .wr_sel    (cfg_sel),
    .held_valid(held_valid),
    .held_id   (held_id),
    .held_fn   (held_fn)
  );

  tpfu_tag_cmp #(.ID_W(ID_W)) u_cmp (
    .held_valid(held_valid),
    .held_id   (held_id),
    .req_id    (iss_id),
    .hit       (hit)
  );

  tpfu_func_core #(.DATA_W(DATA_W)) u_core (
    .fn(held_fn),
    .a (iss_a),
    .b (iss_b),
    .y (core_y)
  );

  // A load in progress holds off issue so no instruction sees a half-changed configuration.
  assign iss_ready = !cfg_we;
  assign accept    = iss_valid && iss_ready;
  assign res_valid = accept && hit;
  assign fault     = accept && !hit;
  assign res_data  = res_valid ? core_y : '0;
endmodule

// File: rtl/tpfu_chk.sv
module tpfu_chk #(
  parameter int ID_W   = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [ID_W-1:0]   iss_id,
  input logic [DATA_W-1:0] iss_a,
  input logic [DATA_W-1:0] iss_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              fault,
  input logic              cfg_we,
  input logic [ID_W-1:0]   cfg_id
);
  AST_NO_DUAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && fault)); // R4
  AST_OUT_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || fault) |-> (iss_valid && iss_ready)); // R4
  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0)); // R3
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !iss_ready); // R5
  AST_LOAD_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && iss_valid && iss_ready && (iss_id == $past(cfg_id))) |-> res_valid); // R2
  AST_LOAD_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && iss_valid && iss_ready && (iss_id != $past(cfg_id))) |-> fault); // R3
  AST_STATELESS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && !cfg_we && !$past(cfg_we) && $stable(iss_id)
     && $stable(iss_a) && $stable(iss_b)) |-> ($stable(res_data) && $stable(res_valid))); // R7
endmodule

bind tpfu_unit tpfu_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_id(iss_id), .iss_a(iss_a), .iss_b(iss_b), .res_valid(res_valid),
  .res_data(res_data), .fault(fault), .cfg_we(cfg_we), .cfg_id(cfg_id)
);

// File: tb/sim_tpfu_unit.sv
`timescale 1ns/1ps
module sim_tpfu_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic        iss_ready;
  logic [10:0] iss_id;
  logic [31:0] iss_a, iss_b;
  logic        res_valid;
  logic [31:0] res_data;
  logic        fault;
  logic        cfg_we;
  logic [10:0] cfg_id;
  logic [2:0]  cfg_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpfu_unit u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_id(iss_id), .iss_a(iss_a), .iss_b(iss_b), .res_valid(res_valid),
    .res_data(res_data), .fault(fault), .cfg_we(cfg_we), .cfg_id(cfg_id),
    .cfg_sel(cfg_sel)
  );

  function automatic logic [31:0] model(logic [2:0] s, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    case (s)
      3'd0: r = a + b;
      3'd1: r = a - b;
      3'd2: r = a ^ b;
      3'd3: r = a & b;
      3'd4: r = a << b[4:0];
      3'd5: r = a >> b[4:0];
      3'd6: r = 32'($countones(a));
      default: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
    endcase
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 ns later (outputs are combinational from inputs).
  task automatic step;
    @(negedge clk);
  endtask

  task automatic load(logic [10:0] id, logic [2:0] s);
    step();
    cfg_we = 1'b1; cfg_id = id; cfg_sel = s; iss_valid = 1'b0;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic issue_hit(string req, logic [10:0] id, logic [2:0] s, logic [31:0] a, logic [31:0] b);
    iss_valid = 1'b1; iss_id = id; iss_a = a; iss_b = b;
    #1;
    chk({req, " res_valid"}, 32'(res_valid), 32'd1);
    chk({req, " fault"}, 32'(fault), 32'd0);
    chk({req, " res_data"}, res_data, model(s, a, b));
  endtask

  task automatic issue_miss(string req, logic [10:0] id);
    iss_valid = 1'b1; iss_id = id; iss_a = $urandom; iss_b = $urandom;
    #1;
    chk({req, " fault"}, 32'(fault), 32'd1);
    chk({req, " res_valid"}, 32'(res_valid), 32'd0);
    chk({req, " res_data zero"}, res_data, 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] id;
    logic [2:0]  s;
    logic [31:0] a, b;
    void'($urandom(32'd1234));
    rst_n = 1'b0; iss_valid = 1'b0; iss_id = '0; iss_a = '0; iss_b = '0;
    cfg_we = 1'b0; cfg_id = '0; cfg_sel = '0;
    repeat (3) step();
    #1;
    chk("R4 idle res_valid in reset", 32'(res_valid), 32'd0);
    chk("R4 idle fault in reset", 32'(fault), 32'd0);
    step(); rst_n = 1'b1;
    step();
    // R1: invalid config, even id 0 misses
    issue_miss("R1 first issue id0", 11'd0);
    step(); iss_valid = 1'b0; #1;
    chk("R4 no issue no fault", 32'(fault), 32'd0);
    chk("R5 ready idle", 32'(iss_ready), 32'd1);

    // R5: load cycle blocks issue; new id effective next cycle
    step();
    cfg_we = 1'b1; cfg_id = 11'h155; cfg_sel = 3'd0;
    iss_valid = 1'b1; iss_id = 11'h155; iss_a = 32'd5; iss_b = 32'd7;
    #1;
    chk("R5 ready low in load", 32'(iss_ready), 32'd0);
    chk("R5 no result in load", 32'(res_valid), 32'd0);
    chk("R5 no fault in load", 32'(fault), 32'd0);
    step(); cfg_we = 1'b0;
    issue_hit("R5 effective next cycle", 11'h155, 3'd0, 32'd5, 32'd7);
    step();
    issue_hit("R2 add wrap", 11'h155, 3'd0, 32'hFFFF_FFFF, 32'd2);
    step();
    // R8: bit 10 only differs
    issue_miss("R8 bit10 differs", 11'h555);
    step();
    issue_miss("R3 neighbour id", 11'h154);

    // R6: every selector, directed corners
    load(11'h7FF, 3'd1); issue_hit("R6 sub borrow", 11'h7FF, 3'd1, 32'd0, 32'd1);
    load(11'h001, 3'd2); issue_hit("R6 xor", 11'h001, 3'd2, 32'hA5A5_0F0F, 32'hFFFF_0000);
    load(11'h002, 3'd3); issue_hit("R6 and", 11'h002, 3'd3, 32'h1234_5678, 32'h0F0F_0F0F);
    load(11'h003, 3'd4); issue_hit("R6 shl by 31", 11'h003, 3'd4, 32'h0000_0003, 32'hFFFF_FFFF);
    load(11'h004, 3'd5); issue_hit("R6 shr high bits ignored", 11'h004, 3'd5, 32'h8000_0000, 32'h0000_0124);
    load(11'h005, 3'd6); issue_hit("R6 popcount all ones", 11'h005, 3'd6, 32'hFFFF_FFFF, 32'd0);
    load(11'h006, 3'd7); issue_hit("R6 byte reverse", 11'h006, 3'd7, 32'h1122_3344, 32'd0);
    #1 chk("R6 byte reverse value", res_data, 32'h4433_2211);
    // old id now misses
    step(); issue_miss("R3 old id after reload", 11'h005);

    // R7: same inputs after unrelated history give same result
    load(11'h0AA, 3'd0);
    issue_hit("R7 first", 11'h0AA, 3'd0, 32'd100, 32'd23);
    step(); issue_hit("R7 other operands", 11'h0AA, 3'd0, 32'hDEAD_BEEF, 32'h1);
    step(); issue_miss("R7 intervening miss", 11'h0AB);
    step(); issue_hit("R7 repeat", 11'h0AA, 3'd0, 32'd100, 32'd23);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      id = 11'($urandom); s = 3'($urandom);
      load(id, s);
      for (int k = 0; k < 4; k++) begin
        a = $urandom; b = $urandom;
        if ($urandom_range(0, 3) == 0)
          issue_miss("R3 random miss", id ^ (11'd1 << $urandom_range(0, 10)));
        else
          issue_hit("R2 random hit", id, s, a, b);
        step();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule